// File: doc/BRIEF.md
# Processor-to-ISA I/O Address Translator

This block bridges a memory-mapped window on the processor side to an ISA-style I/O port bus. A processor access that lands inside an 8 MB window starting at 0x80000000 is turned into an I/O port read or write. The access keeps its size (byte, halfword or word), its direction and its data. Read data goes back to the processor with the acknowledge. Accesses that fall outside the window get no response and have no effect on the I/O side.

The port address depends on a map-mode input that comes from a register elsewhere. In flat mode the low 16 bits of the window offset form the port number, which gives a 64 KB port space. In sparse mode each 4 KB processor page selects its own 32-byte group of ports. This lets software give each group of ports a page of its own for protection. Only one access is in flight at a time. The processor holds its request until it sees the acknowledge.

Top module: `isa_io_bridge`

## Requirements
- R1: A request is accepted only when its address lies in [0x80000000, 0x80800000). Outside that range no I/O request is raised and no acknowledge is returned.
- R2: With `map_sparse` = 0 the port address is the window offset ANDed with 0xFFFF.
- R3: With `map_sparse` = 1 the port address is bits 4..0 of the offset in port bits 4..0, and offset bits 22..12 in port bits 15..5. Offset bits 11..5 have no effect, so two addresses that differ only there reach the same port.
- R4: `map_sparse` is sampled in the cycle a request is accepted. A later change leaves the port address of the access in flight unchanged.
- R5: Direction, size code (0 = byte, 1 = halfword, 2 or 3 = word) and write data are forwarded unchanged, with no byte reordering.
- R6: `io_req` rises in the cycle after acceptance and stays high, with stable address, until the cycle after `io_ack`. No second access starts while one is outstanding.
- R7: `cpu_ack` is a single-cycle pulse in the cycle after `io_ack`. For a read, `cpu_rdata` carries `io_rdata` with lanes above the access size cleared (byte keeps bits 7..0, halfword bits 15..0, word all). For a write, `cpu_rdata` is zero.
- R8: During and right after reset, `io_req` and `cpu_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_sparse | input | 1 | Map mode: 0 flat 64 KB, 1 sparse paged |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Access size code |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | Completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| io_req | output | 1 | I/O access request |
| io_we | output | 1 | I/O write strobe |
| io_size | output | 2 | I/O access size code |
| io_addr | output | 16 | I/O port address |
| io_wdata | output | 32 | I/O write data |
| io_ack | input | 1 | I/O completion, one cycle |
| io_rdata | input | 32 | I/O read data, valid with `io_ack` |

## Verification
The hardest case to reach from the ports is a change of map mode while an access is already outstanding. The bench provokes it by stretching the I/O responder's latency to several cycles and then flipping `map_sparse` after acceptance. The reference model must keep the port address it computed at acceptance. Aliasing in sparse mode is driven by pairs of addresses that differ only in offset bits 11..5. The window edges are hit with the last byte inside the window and the first byte beyond it on either side.

// File: rtl/isa_io_bridge.sv
module isa_io_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IO_AW = 16,
  parameter int GROUP_BITS = 5,
  parameter int PAGE_BITS = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] WIN_SPAN = 32'h0080_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_sparse,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              io_req,
  output logic              io_we,
  output logic [1:0]        io_size,
  output logic [IO_AW-1:0]  io_addr,
  output logic [DATA_W-1:0] io_wdata,
  input  logic              io_ack,
  input  logic [DATA_W-1:0] io_rdata
);
  localparam int OFF_W = $clog2(WIN_SPAN);
  localparam int SPARSE_W = OFF_W - PAGE_BITS + GROUP_BITS;

  typedef enum logic [1:0] {IDLE, BUSY, DONE} state_t;
  state_t state;

  logic [ADDR_W-1:0] off;
  logic              in_win, accept;
  logic [IO_AW-1:0]  flat_addr, sparse_addr;
  logic [DATA_W-1:0] lane_mask;

  assign off    = cpu_addr - WIN_BASE;
  assign in_win = (cpu_addr >= WIN_BASE) && (off < WIN_SPAN);
  assign accept = (state == IDLE) && cpu_req && in_win;

  assign flat_addr   = off[IO_AW-1:0];
  assign sparse_addr = IO_AW'({off[OFF_W-1:PAGE_BITS], off[GROUP_BITS-1:0]});

  always_comb begin
    case (io_size)
      2'd0:    lane_mask = DATA_W'(8'hFF);
      2'd1:    lane_mask = DATA_W'(16'hFFFF);
      default: lane_mask = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      io_req    <= 1'b0;
      cpu_ack   <= 1'b0;
      cpu_rdata <= '0;
      io_we     <= 1'b0;
      io_size   <= '0;
      io_addr   <= '0;
      io_wdata  <= '0;
    end else begin
      cpu_ack <= 1'b0;
      case (state)
        IDLE: if (accept) begin
          state    <= BUSY;
          io_req   <= 1'b1;
          io_we    <= cpu_we;
          io_size  <= cpu_size;
          io_wdata <= cpu_wdata;
          io_addr  <= map_sparse ? sparse_addr : flat_addr;
        end
        BUSY: if (io_ack) begin
          state     <= DONE;
          io_req    <= 1'b0;
          cpu_ack   <= 1'b1;
          cpu_rdata <= io_we ? '0 : (io_rdata & lane_mask);
        end
        default: state <= IDLE;
      endcase
    end
  end

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && !io_ack |=> io_req);
  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && $past(io_req) |-> $stable(io_addr) && $stable(io_size) && $stable(io_we));
  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);
  assert_ack_follows_io_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_ack) |-> $past(io_ack) && $past(io_req));
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ack && io_req));
  assert_byte_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && io_size == 2'd0 |-> cpu_rdata[DATA_W-1:8] == '0);
  assert_idle_after_reset_R8: assert property (@(posedge clk)
    $rose(rst_n) |-> !io_req && !cpu_ack);
endmodule

// File: tb/sim_isa_io_bridge.sv
`timescale 1ns/1ps
module sim_isa_io_bridge;
  logic clk = 0, rst_n = 0, map_sparse = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [1:0] cpu_size = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic cpu_ack, io_req, io_we;
  logic [31:0] cpu_rdata, io_wdata;
  logic [1:0] io_size;
  logic [15:0] io_addr;
  logic io_ack = 0;
  logic [31:0] io_rdata = 0;

  int tests = 0, fails = 0, lat = 0, cnt = 0, cycles = 0;
  int ph = 0;
  logic [15:0] e_addr;
  logic [1:0] e_size;
  logic e_we;
  logic [31:0] e_wdata, e_rdata;

  always #2.5 clk = ~clk;

  isa_io_bridge u0 (.clk, .rst_n, .map_sparse, .cpu_req, .cpu_we, .cpu_size,
    .cpu_addr, .cpu_wdata, .cpu_ack, .cpu_rdata, .io_req, .io_we, .io_size,
    .io_addr, .io_wdata, .io_ack, .io_rdata);

  function automatic logic [15:0] xlate(logic [31:0] a, logic sp);
    longint o = longint'(a) - 64'h8000_0000;
    if (sp) return 16'((o & 'h1F) | ((o & 'h7FF000) >> 7));
    return 16'(o & 'hFFFF);
  endfunction

  function automatic bit inside_win(logic [31:0] a);
    return a >= 32'h8000_0000 && a <= 32'h807F_FFFF;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: advances on each rising edge from the inputs it saw
  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else case (ph)
      0: if (cpu_req && inside_win(cpu_addr)) begin
           ph = 1; e_addr = xlate(cpu_addr, map_sparse);
           e_size = cpu_size; e_we = cpu_we; e_wdata = cpu_wdata;
         end
      1: if (io_ack) begin
           ph = 2;
           if (e_we) e_rdata = 0;
           else if (e_size == 0) e_rdata = io_rdata & 32'hFF;
           else if (e_size == 1) e_rdata = io_rdata & 32'hFFFF;
           else e_rdata = io_rdata;
         end
      default: ph = 0;
    endcase
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk(io_req == (ph == 1), "R1/R6 io_req", io_req, ph == 1);
    chk(cpu_ack == (ph == 2), "R7 cpu_ack", cpu_ack, ph == 2);
    if (ph == 1) begin
      chk(io_addr == e_addr, map_sparse ? "R3/R4 io_addr" : "R2/R4 io_addr", io_addr, e_addr);
      chk(io_we == e_we && io_size == e_size, "R5 dir/size", {io_we, io_size}, {e_we, e_size});
      if (e_we) chk(io_wdata == e_wdata, "R5 wdata", io_wdata, e_wdata);
    end
    if (ph == 2) chk(cpu_rdata == e_rdata, "R7 rdata", cpu_rdata, e_rdata);
  end

  // I/O responder with programmable latency
  always @(negedge clk) begin
    if (io_ack) io_ack = 0;
    else if (io_req) begin
      if (cnt >= lat) begin
        io_ack = 1; io_rdata = {io_addr ^ 16'h5A3C, io_addr}; cnt = 0;
      end else cnt++;
    end else cnt = 0;
  end

  task automatic access(bit we, logic [31:0] a, logic [1:0] sz, logic [31:0] wd,
                        int l, bit flip_mode = 0);
    @(negedge clk);
    lat = l; cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (flip_mode && i == 1) map_sparse = ~map_sparse;
      if (cpu_ack) break;
      if (!inside_win(a) && i == 6) break;
    end
    cpu_req = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(io_req == 0 && cpu_ack == 0, "R8 reset", {io_req, cpu_ack}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(io_req == 0 && cpu_ack == 0, "R8 after reset", {io_req, cpu_ack}, 0);
    // R2 flat mode, all sizes, reads and writes
    access(0, 32'h8000_03F8, 0, 0, 0);
    access(1, 32'h8012_1234, 2, 32'hDEAD_BEEF, 2);
    access(0, 32'h807F_FFFE, 1, 0, 1);
    access(0, 32'h8000_0070, 3, 0, 0);
    // R3 sparse mode and aliasing over offset bits 11..5
    map_sparse = 1;
    access(0, 32'h8012_3015, 1, 0, 1);
    access(0, 32'h8012_3FF5, 1, 0, 1);
    access(1, 32'h807F_FFFF, 0, 32'h0000_00A7, 3);
    access(0, 32'h8000_0FE0, 2, 0, 0);
    // R1 window edges
    access(0, 32'h7FFF_FFFF, 0, 0, 0);
    access(1, 32'h8080_0000, 2, 32'h1111_2222, 0);
    access(0, 32'hFFFF_FFFC, 2, 0, 0);
    access(0, 32'h8000_0000, 0, 0, 0);
    // R4 mode flips while the access is outstanding
    access(0, 32'h8034_5A67, 2, 0, 6, 1);
    access(1, 32'h8034_5A67, 1, 32'h0000_BEEF, 6, 1);
    // R6 long latency, back to back
    for (int k = 0; k < 8; k++)
      access(k[0], 32'h8000_0000 + 32'(k * 32'h1_3579), 2'(k), 32'hC0DE_0000 + k, k);
    // R8 reset mid access
    @(negedge clk);
    lat = 20; cpu_req = 1; cpu_we = 0; cpu_addr = 32'h8000_1000; cpu_size = 2;
    repeat (3) @(negedge clk);
    rst_n = 0; cpu_req = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(io_req == 0 && cpu_ack == 0, "R8 reset mid access", {io_req, cpu_ack}, 0);
    repeat (30) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule